// File: doc/BRIEF.md
# Translation Fault Status and Control Registers

This block sits beside an address translator and keeps the state that software uses to run it and to deal with its faults. A small control register holds one of three states: off, running, or running but stalled. The translation and bus logic report fault events one per cycle, each with a type code and the address involved. Every event sets one bit of an interrupt status word, and the address is stored in one of four capture registers. Several fault types share one capture register, sorted by the bus channel on which they occur.

While any status bit is set, the interrupt line is high. A fault that arrives while the translator is running moves the control register into the stalled state on its own, and the stall output holds the translation path. Software reads the lowest pending fault type first, reads the matching capture register, and clears that bit with a one-hot write. When no bit remains set, software writes the running code again to let translation resume.

Register access uses a plain bus: a write strobe, an offset, write data and read data that follow the offset in the same cycle.

Top module: `xfc_top`

## Requirements
- R1: After reset the control register at offset 0x00 reads 0x0. Writing 0x0 (off), 0x5 (running) or 0x7 (stalled) stores that code, and the code reads back from the next cycle.
- R2: A write of any other value to offset 0x00 leaves the control register unchanged.
- R3: A fault event of type t (0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access) sets bit t of the status word at offset 0x18 from the next cycle.
- R4: The event address is captured by type. Type 0 goes to offset 0x24. Types 2, 6 and 7 go to offset 0x28. Types 1, 4 and 5 go to offset 0x2C. Type 3 goes to offset 0x30.
- R5: A capture register loads only when the event's status bit is clear before the event. A repeat of a type whose bit is still set leaves its address unchanged.
- R6: The `irq` output is high in every cycle in which any status bit is set.
- R7: `head_type` gives the lowest-numbered set status bit.
- R8: Writing to offset 0x1C clears every status bit that is set in the written word. A zero word changes nothing. An event that arrives in the same cycle as the clear of its own bit leaves that bit set.
- R9: A fault event while the control register holds 0x5 turns it into 0x7 and raises `xlat_stall`. A fault while it holds 0x0 leaves it at 0x0.
- R10: Writing 0x5 while any status bit remains set after that cycle's update gives 0x7. Once the status word is zero, writing 0x5 resumes translation and clears `xlat_stall`.
- R11: Offsets that hold no register, for example 0x04, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_valid | input | 1 | Fault event strobe |
| flt_type | input | 3 | Fault type code of the event |
| flt_addr | input | 32 | Address associated with the event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` |
| irq | output | 1 | High while any fault is pending |
| xlat_stall | output | 1 | Holds the translation path (control register is 0x7) |
| xlat_en | output | 1 | Translation switched on (control register is not 0x0) |
| head_type | output | 3 | Lowest-numbered pending fault type |

## Verification
The bench builds the block with its default parameters: eight fault types, four capture registers and 32-bit addresses. These values allow every type code to be driven, and every capture register can be reached through its offset at full width. This lets the bench pile up pending faults on shared and separate capture registers. It can then follow the lowest-first order while bits are cleared one at a time, and it tests that the stalled state holds until the status word has been emptied.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam int NFLT = 8;
  localparam int NCAP = 4;
  localparam int DW   = 32;
  localparam int OW   = 8;

  localparam logic [2:0] CTL_OFF   = 3'h0;
  localparam logic [2:0] CTL_RUN   = 3'h5;
  localparam logic [2:0] CTL_STALL = 3'h7;

  localparam logic [OW-1:0] OFS_CTL   = 8'h00;
  localparam logic [OW-1:0] OFS_STAT  = 8'h18;
  localparam logic [OW-1:0] OFS_CLR   = 8'h1C;
  localparam logic [OW-1:0] OFS_PGF   = 8'h24;
  localparam logic [OW-1:0] OFS_WRF   = 8'h28;
  localparam logic [OW-1:0] OFS_RDF   = 8'h2C;
  localparam logic [OW-1:0] OFS_DFS   = 8'h30;

  // capture slot numbering: 0 page, 1 read channel, 2 write channel, 3 default slave
  function automatic int unsigned cap_slot(input int unsigned ftype);
    case (ftype)
      0:       return 0;
      1, 4, 5: return 1;
      2, 6, 7: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic bit ctl_code_ok(input logic [DW-1:0] v);
    return (v == DW'(CTL_OFF)) || (v == DW'(CTL_RUN)) || (v == DW'(CTL_STALL));
  endfunction
endpackage

// File: rtl/xfc_status.sv
module xfc_status #(
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  output logic [NF-1:0] stat_q,
  output logic [NF-1:0] stat_d,
  output logic [NF-1:0] rise_vec
);
  // a new event beats a clear of the same bit in one cycle
  assign stat_d   = (stat_q & ~clr_vec) | set_vec;
  assign rise_vec = set_vec & ~stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/xfc_capture.sv
module xfc_capture #(
  parameter int NF = 8,
  parameter int NC = 4,
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NF-1:0]  rise_vec,
  input  logic [AW-1:0]  addr,
  output logic [NC-1:0]  cap_load,
  output logic [NC*AW-1:0] cap_flat
);
  import xfc_pkg::*;

  for (genvar k = 0; k < NC; k++) begin : g_slot
    logic [AW-1:0] slot_q;

    always_comb begin
      cap_load[k] = 1'b0;
      for (int t = 0; t < NF; t++)
        if (rise_vec[t] && cap_slot(t) == k) cap_load[k] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           slot_q <= '0;
      else if (cap_load[k]) slot_q <= addr;
    end

    assign cap_flat[k*AW +: AW] = slot_q;
  end
endmodule

// File: rtl/xfc_prio.sv
module xfc_prio #(
  parameter int NF = 8,
  localparam int TW = $clog2(NF)
) (
  input  logic [NF-1:0] vec,
  output logic [TW-1:0] idx
);
  // scan from the top so the lowest set bit is written last
  always_comb begin
    idx = '0;
    for (int i = NF - 1; i >= 0; i--)
      if (vec[i]) idx = TW'(i);
  end
endmodule

// File: rtl/xfc_top.sv
module xfc_top #(
  parameter int NF = xfc_pkg::NFLT,
  parameter int NC = xfc_pkg::NCAP,
  parameter int AW = 32,
  localparam int TW = $clog2(NF),
  localparam int DW = xfc_pkg::DW,
  localparam int OW = xfc_pkg::OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flt_valid,
  input  logic [TW-1:0] flt_type,
  input  logic [AW-1:0] flt_addr,
  input  logic          reg_wr,
  input  logic [OW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          xlat_stall,
  output logic          xlat_en,
  output logic [TW-1:0] head_type
);
  import xfc_pkg::*;

  logic [NF-1:0]    set_vec, clr_vec, stat_q, stat_d, rise_vec;
  logic [NC-1:0]    cap_load;
  logic [NC*AW-1:0] cap_flat;
  logic [2:0]       ctl_q, ctl_d;
  logic             wr_ctl, wr_clr;

  assign wr_ctl  = reg_wr && (reg_addr == OFS_CTL);
  assign wr_clr  = reg_wr && (reg_addr == OFS_CLR);
  assign set_vec = flt_valid ? (NF'(1) << flt_type) : '0;
  assign clr_vec = wr_clr ? reg_wdata[NF-1:0] : '0;

  xfc_status #(.NF(NF)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .stat_q(stat_q), .stat_d(stat_d), .rise_vec(rise_vec)
  );

  xfc_capture #(.NF(NF), .NC(NC), .AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .rise_vec(rise_vec), .addr(flt_addr),
    .cap_load(cap_load), .cap_flat(cap_flat)
  );

  xfc_prio #(.NF(NF)) u_prio (.vec(stat_q), .idx(head_type));

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl && ctl_code_ok(reg_wdata)) begin
      if (reg_wdata[2:0] == CTL_RUN && stat_d != '0) ctl_d = CTL_STALL;
      else                                            ctl_d = reg_wdata[2:0];
    end else if (ctl_q == CTL_RUN && set_vec != '0) begin
      ctl_d = CTL_STALL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_OFF;
    else        ctl_q <= ctl_d;
  end

  assign irq        = |stat_q;
  assign xlat_stall = (ctl_q == CTL_STALL);
  assign xlat_en    = (ctl_q != CTL_OFF);

  always_comb begin
    case (reg_addr)
      OFS_CTL:  reg_rdata = DW'(ctl_q);
      OFS_STAT: reg_rdata = DW'(stat_q);
      OFS_PGF:  reg_rdata = DW'(cap_flat[0*AW +: AW]);
      OFS_RDF:  reg_rdata = DW'(cap_flat[1*AW +: AW]);
      OFS_WRF:  reg_rdata = DW'(cap_flat[2*AW +: AW]);
      OFS_DFS:  reg_rdata = DW'(cap_flat[3*AW +: AW]);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
  parameter int NF = 8,
  parameter int NC = 4,
  parameter int AW = 32,
  parameter int TW = 3,
  parameter int DW = 32,
  parameter int OW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flt_valid,
  input logic [TW-1:0]    flt_type,
  input logic             reg_wr,
  input logic [OW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic             irq,
  input logic             xlat_stall,
  input logic             xlat_en,
  input logic [TW-1:0]    head_type,
  input logic [NF-1:0]    stat_q,
  input logic [2:0]       ctl_q,
  input logic [NC*AW-1:0] cap_flat
);
  assert_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == 3'h0) || (ctl_q == 3'h5) || (ctl_q == 3'h7));

  assert_event_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> irq);

  assert_keep_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && stat_q[flt_type]) |=> $stable(cap_flat));

  assert_head_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q[head_type] && ((stat_q & ((NF'(1) << head_type) - NF'(1))) == '0)));

  assert_zero_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h1C && reg_wdata == '0 && !flt_valid) |=> $stable(stat_q));

  assert_auto_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && ctl_q == 3'h5 && !reg_wr) |=> xlat_stall);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && xlat_en) |-> xlat_stall);
endmodule

bind xfc_top xfc_checker #(
  .NF(NF), .NC(NC), .AW(AW), .TW(TW), .DW(DW), .OW(OW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_type(flt_type),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq(irq), .xlat_stall(xlat_stall), .xlat_en(xlat_en),
  .head_type(head_type), .stat_q(stat_q), .ctl_q(ctl_q), .cap_flat(cap_flat)
);

// File: tb/xfc_top_test.sv
module xfc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid = 1'b0;
  logic [2:0]  flt_type = '0;
  logic [31:0] flt_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, xlat_stall, xlat_en;
  logic [2:0]  head_type;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;   // 0 register read, 1 irq, 2 stall, 3 head type
    logic [31:0] exp;
    string req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  xfc_top uut (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_type(flt_type),
    .flt_addr(flt_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .xlat_stall(xlat_stall), .xlat_en(xlat_en), .head_type(head_type)
  );

  // monitor: pops one expected item per cycle, away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = reg_rdata;
        1:       act = {31'b0, irq};
        2:       act = {31'b0, xlat_stall};
        default: act = {29'b0, head_type};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    flt_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic fault(input int t, input logic [31:0] a);
    step(); flt_valid = 1'b1; flt_type = 3'(t); flt_addr = a;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
    item_t it;
    step(); reg_addr = a;
    it.kind = 0; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic pin(input int k, input logic [31:0] e, input string r);
    item_t it;
    step();
    it.kind = k; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state
    rd(8'h00, 32'h0, "R1 reset ctl");
    rd(8'h18, 32'h0, "R3 reset status");
    pin(1, 0, "R6 reset irq");
    pin(2, 0, "R9 reset stall");
    // R1 / R2 control codes
    wr(8'h00, 32'h5);
    rd(8'h00, 32'h5, "R1 run code");
    wr(8'h00, 32'h3);
    rd(8'h00, 32'h5, "R2 invalid code ignored");
    wr(8'h00, 32'h7);
    rd(8'h00, 32'h7, "R1 stall code");
    wr(8'h00, 32'h5);
    pin(2, 0, "R1 run not stalled");
    // bus error while running
    fault(3, 32'hD000_0030);
    rd(8'h18, 32'h08, "R3 bus error bit");
    pin(1, 1, "R6 irq on fault");
    pin(2, 1, "R9 auto stall");
    rd(8'h00, 32'h7, "R9 ctl stalled");
    rd(8'h30, 32'hD000_0030, "R4 default slave capture");
    // read access fault
    fault(5, 32'hA000_0500);
    rd(8'h18, 32'h28, "R3 two bits");
    rd(8'h2C, 32'hA000_0500, "R4 read channel capture");
    pin(3, 3, "R7 lowest first");
    fault(5, 32'hBBBB_0000);
    rd(8'h2C, 32'hA000_0500, "R5 no overwrite");
    fault(0, 32'h1234_5000);
    pin(3, 0, "R7 page fault first");
    rd(8'h24, 32'h1234_5000, "R4 page capture");
    wr(8'h00, 32'h5);
    rd(8'h00, 32'h7, "R10 run refused while pending");
    wr(8'h1C, 32'h0);
    rd(8'h18, 32'h29, "R8 zero clear no effect");
    wr(8'h1C, 32'h1);
    rd(8'h18, 32'h28, "R8 clear bit0");
    pin(3, 3, "R7 next head");
    wr(8'h1C, 32'h08);
    pin(3, 5, "R7 last head");
    // clear and event same bit in one cycle
    step(); reg_wr = 1'b1; reg_addr = 8'h1C; reg_wdata = 32'h20;
    flt_valid = 1'b1; flt_type = 3'd5; flt_addr = 32'hCCCC_0000;
    rd(8'h18, 32'h20, "R8 event wins over clear");
    rd(8'h2C, 32'hA000_0500, "R5 bit stayed set so no reload");
    wr(8'h1C, 32'h20);
    pin(1, 0, "R6 irq drops");
    rd(8'h00, 32'h7, "R10 still stalled after clear");
    wr(8'h00, 32'h5);
    pin(2, 0, "R10 resume");
    // recapture after clear, write channel sharing
    fault(5, 32'hC000_0005);
    rd(8'h2C, 32'hC000_0005, "R5 recapture after clear");
    fault(7, 32'hE000_0007);
    rd(8'h28, 32'hE000_0007, "R4 write channel capture");
    fault(2, 32'hE000_0002);
    rd(8'h28, 32'hE000_0002, "R4 shared write register reload");
    fault(6, 32'hE000_0006);
    rd(8'h18, 32'hE4 | 32'h20, "R3 write faults bits");
    rd(8'h28, 32'hE000_0006, "R5 new bit six loads shared register");
    // disable and fault while off
    wr(8'h00, 32'h0);
    pin(2, 0, "R1 off unstalled");
    wr(8'h1C, 32'hFF);
    fault(1, 32'h0000_0101);
    rd(8'h00, 32'h0, "R9 off stays off");
    rd(8'h18, 32'h02, "R3 read multi-hit bit");
    rd(8'h2C, 32'h0000_0101, "R4 read multi-hit capture");
    rd(8'h04, 32'h0, "R11 empty offset");
    step(); step();
    wait (sb.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule